// File: doc/BRIEF.md
# Self-Starting Wake-up Down-Counter

This block is a loadable down-counter used to wake a chip from a low-power state or as a plain interval timer. Software writes a count value; any non-zero value both loads the counter and starts it, with no separate enable. The counter then decrements once per strobe of the chosen time base. When it reaches zero it stops, holds at zero and raises a sticky alarm. The alarm drives an interrupt line and a wake request until software clears it.

Two time bases reach the block as single-cycle enable strobes on the system clock. One strobe comes from a slow low-power oscillator and the other from a faster internal oscillator. A control register picks between them, clears the alarm, and can abort a running count. The register port has one write channel and one combinational read channel. Address 0 selects the control register and address 1 selects the count register.

Top module: `wkt_counter_top`

## Requirements
- R1: After reset the count reads 0, the counter is idle, the alarm is 0, the source select is 0, and `irq` and `wake_req` are low.
- R2: A write of a non-zero value to address 1 loads that value and starts counting, even if the counter is already running. After the write, each strobe of the selected source lowers the count by one.
- R3: When a running count goes from 1 to 0, the counter stops and holds 0. In the same edge the alarm sets, and `irq` and `wake_req` go high.
- R4: Control bit 0 selects the time base: 0 selects `lp_tick` and 1 selects `fast_tick`. Strobes on the source that is not selected do not change the count.
- R5: A write of 0 to address 1 does not start an idle counter. A zero write to a running counter leaves its count and its running state unchanged.
- R6: The alarm (control bit 1) stays set until a control write with bit 1 = 1. A control write with bit 1 = 0 leaves it set. If an expiry happens in the same cycle as a clearing write, the alarm stays set.
- R7: A control write with bit 2 = 1 stops the counter and forces the count to 0 without setting the alarm. It also wins over an expiry in the same cycle.
- R8: A control write made while the counter runs leaves the source select (control bit 0) unchanged.
- R9: A read of address 1 returns the current count. A read of address 0 returns the select in bit 0 and the alarm in bit 1, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_tick | input | 1 | Low-power oscillator enable strobe |
| fast_tick | input | 1 | Internal fast oscillator enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 count |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 count |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt, high while the alarm is set |
| wake_req | output | 1 | Wake request, high while the alarm is set |

## Verification
The bench targets the same-cycle collisions:
- Expiry against an alarm-clearing write. A design that ordered these the wrong way would lose a wake event.
- Expiry against an abort. A wrong design would raise a false alarm after software cancelled the count.

It also drives zero writes to a running counter, and select changes in the middle of a count. A careless design would stop the timer on the first, or would switch its rate unseen on the second. Strobes on the source that is not selected check that the counter does not decrement on the wrong oscillator. A long random run with short counts reaches expiry many times under mixed traffic.

// File: rtl/wkt_pkg.sv
`timescale 1ns/1ps
package wkt_pkg;
   localparam logic ADR_CTRL  = 1'b0;
   localparam logic ADR_COUNT = 1'b1;
   localparam int   CB_SEL    = 0;
   localparam int   CB_ALARM  = 1;
   localparam int   CB_ABORT  = 2;
   typedef enum logic {SRC_LP = 1'b0, SRC_FAST = 1'b1} src_e;
endpackage

// File: rtl/wkt_tick_mux.sv
`timescale 1ns/1ps
module wkt_tick_mux
   import wkt_pkg::*;
(
   input  src_e sel,
   input  logic lp_tick,
   input  logic fast_tick,
   output logic tick
);
   always_comb begin
      unique case (sel)
         SRC_FAST: tick = fast_tick;
         default:  tick = lp_tick;
      endcase
   end
endmodule

// File: rtl/wkt_count_core.sv
`timescale 1ns/1ps
module wkt_count_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             abort,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             step;

   assign step   = run_q && tick && !load && !abort;
   assign expire = step && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (abort) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         run_q <= 1'b1;
      end else if (step) begin
         cnt_q <= cnt_q - ONE;
         if (cnt_q == ONE) run_q <= 1'b0;
      end
   end

   assign cnt     = cnt_q;
   assign running = run_q;
endmodule

// File: rtl/wkt_ctrl_regs.sv
`timescale 1ns/1ps
module wkt_ctrl_regs
   import wkt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_wr,
   input  logic sel_in,
   input  logic alarm_clr,
   input  logic running,
   input  logic expire,
   output src_e sel,
   output logic alarm
);
   src_e sel_q;
   logic alarm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= SRC_LP;
         alarm_q <= 1'b0;
      end else begin
         if (ctrl_wr && !running) sel_q <= src_e'(sel_in);
         if (expire)              alarm_q <= 1'b1;
         else if (alarm_clr)      alarm_q <= 1'b0;
      end
   end

   assign sel   = sel_q;
   assign alarm = alarm_q;
endmodule

// File: rtl/wkt_counter_top.sv
`timescale 1ns/1ps
module wkt_counter_top
   import wkt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_tick,
   input  logic              fast_tick,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              wake_req
);
   localparam int PAD_W = DATA_W - CNT_W;

   if (CNT_W < 2)       begin : g_bad_cnt  $error("CNT_W must be at least 2");      end
   if (CNT_W > DATA_W)  begin : g_bad_fit  $error("CNT_W must not exceed DATA_W");  end
   if (DATA_W < 3)      begin : g_bad_data $error("DATA_W must hold control bits"); end

   logic             cnt_wr, ctrl_wr, load, abort, tick, expire;
   logic             run_q, alarm_q;
   logic [CNT_W-1:0] cnt_q;
   src_e             sel_q;
   logic [DATA_W-1:0] cnt_rd, ctrl_rd;

   assign cnt_wr  = wr_en && (wr_addr == ADR_COUNT);
   assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
   assign load    = cnt_wr && (wr_data[CNT_W-1:0] != '0);
   assign abort   = ctrl_wr && wr_data[CB_ABORT];

   wkt_tick_mux u_mux (
      .sel(sel_q), .lp_tick(lp_tick), .fast_tick(fast_tick), .tick(tick)
   );

   wkt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data[CNT_W-1:0]),
      .abort(abort), .tick(tick), .cnt(cnt_q), .running(run_q), .expire(expire)
   );

   wkt_ctrl_regs u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .sel_in(wr_data[CB_SEL]),
      .alarm_clr(ctrl_wr && wr_data[CB_ALARM]), .running(run_q),
      .expire(expire), .sel(sel_q), .alarm(alarm_q)
   );

   if (PAD_W > 0) begin : g_pad
      assign cnt_rd = {{PAD_W{1'b0}}, cnt_q};
   end else begin : g_nopad
      assign cnt_rd = cnt_q;
   end

   always_comb begin
      ctrl_rd           = '0;
      ctrl_rd[CB_SEL]   = sel_q;
      ctrl_rd[CB_ALARM] = alarm_q;
   end

   assign rd_data  = (rd_addr == ADR_COUNT) ? cnt_rd : ctrl_rd;
   assign irq      = alarm_q;
   assign wake_req = alarm_q;
endmodule

// File: rtl/wkt_chk.sv
`timescale 1ns/1ps
module wkt_chk #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lp_tick,
   input logic              fast_tick,
   input logic              wr_en,
   input logic              wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              run_q,
   input logic              alarm_q,
   input logic              sel_bit,
   input logic              irq
);
   logic tk, cw, kw;
   assign tk = sel_bit ? fast_tick : lp_tick;
   assign cw = wr_en && wr_addr;
   assign kw = wr_en && !wr_addr;

   AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      cw && (wr_data[CNT_W-1:0] != '0) |=> run_q && cnt_q == $past(wr_data[CNT_W-1:0])); // R2
   AST_EXPIRE_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && tk && cnt_q == CNT_W'(1) && !wr_en |=> !run_q && cnt_q == '0 && alarm_q && irq); // R3
   AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      cw && (wr_data[CNT_W-1:0] == '0) && !run_q |=> !run_q); // R5
   AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_q && !(kw && wr_data[1]) |=> alarm_q); // R6
   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      kw && wr_data[2] && !alarm_q |=> !alarm_q && !run_q && cnt_q == '0); // R7
   AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> $stable(sel_bit)); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q && !cw |=> $stable(cnt_q) || cnt_q == '0); // R3
endmodule

bind wkt_counter_top wkt_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick), .fast_tick(fast_tick),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cnt_q(cnt_q),
   .run_q(run_q), .alarm_q(alarm_q), .sel_bit(sel_q), .irq(irq)
);

// File: tb/tb_wkt_counter_top.sv
`timescale 1ns/1ps
module tb_wkt_counter_top;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        lp_tick = 0, fast_tick = 0, wr_en = 0, wr_addr = 0, rd_addr = 0;
   logic [31:0] wr_data = '0, rd_data;
   logic        irq, wake_req;
   int          checks = 0, errors = 0;
   bit          done = 0;

   // reference state built from the requirements
   logic [31:0] m_cnt = 0;
   bit          m_run = 0, m_alarm = 0, m_sel = 0;

   always #2.5 clk = ~clk;

   wkt_counter_top dut (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void model(bit w, bit a, logic [31:0] d, bit lp, bit fs);
      bit tk = m_sel ? fs : lp;
      bit ld = w && a && d != 0;
      bit ab = w && !a && d[2];
      bit [31:0] c = m_cnt; bit r = m_run, al = m_alarm, s = m_sel;
      if (w && !a) begin
         if (!m_run) s = d[0];
         if (d[1]) al = 0;
      end
      if (ab) begin c = 0; r = 0; end
      else if (ld) begin c = d; r = 1; end
      else if (m_run && tk) begin
         if (m_cnt == 1) begin c = 0; r = 0; al = 1; end
         else c = m_cnt - 1;
      end
      m_cnt = c; m_run = r; m_alarm = al; m_sel = s;
   endfunction

   task automatic step(string tag, bit w, bit a, logic [31:0] d, bit lp, bit fs);
      @(negedge clk);
      wr_en = w; wr_addr = a; wr_data = d; lp_tick = lp; fast_tick = fs;
      @(posedge clk);
      model(w, a, d, lp, fs);
      #0.5 rd_addr = 1'b1;
      #0.5 chk({tag, " count"}, rd_data, m_cnt);
      rd_addr = 1'b0;
      #0.5 chk({tag, " ctrl"}, rd_data, {30'd0, m_alarm, m_sel});
      chk({tag, " irq"}, {30'd0, irq, wake_req}, {30'd0, m_alarm, m_alarm});
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      #12 rst_n = 1'b1;
      // R1 reset state
      @(negedge clk); rd_addr = 1; #0.5 chk("R1 count", rd_data, 0);
      rd_addr = 0; #0.5 chk("R1 ctrl", rd_data, 0);
      chk("R1 irq", {irq, wake_req}, 0);
      // R5 zero write while idle
      step("R5 idle zero", 1, 1, 0, 1, 1);
      step("R5 idle tick", 0, 0, 0, 1, 0);
      // R2/R4 load 3 on low-power source, fast strobes ignored
      step("R2 load", 1, 1, 3, 0, 0);
      step("R4 fast ignored", 0, 0, 0, 0, 1);
      chk("R4 still 3", m_cnt, 3);
      step("R2 dec", 0, 0, 0, 1, 0);
      step("R5 run zero", 1, 1, 0, 0, 0);
      chk("R5 kept 2", m_cnt, 2);
      step("R8 sel while run", 1, 0, 32'h1, 0, 0);
      step("R2 dec", 0, 0, 0, 1, 0);
      // R3/R6 expiry collides with alarm-clear write: alarm stays
      step("R6 clear vs expire", 1, 0, 32'h2, 1, 0);
      chk("R3 expired", {m_cnt[30:0], m_alarm}, 1);
      step("R3 hold", 0, 0, 0, 1, 1);
      step("R6 bit1 zero", 1, 0, 32'h0, 0, 0);
      step("R6 clear", 1, 0, 32'h2, 0, 0);
      chk("R6 cleared", m_alarm, 0);
      // R4 fast source
      step("R4 sel fast", 1, 0, 32'h1, 0, 0);
      step("R2 load fast", 1, 1, 2, 0, 0);
      step("R4 lp ignored", 0, 0, 0, 1, 0);
      step("R4 fast dec", 0, 0, 0, 0, 1);
      // R7 abort collides with expiry: no alarm
      step("R7 abort vs expire", 1, 0, 32'h5, 0, 1);
      chk("R7 no alarm", {m_cnt[30:0], m_alarm}, 0);
      step("R2 reload", 1, 1, 32'hFFFF_FFFF, 0, 1);
      step("R2 reload again", 1, 1, 32'h10, 0, 1);
      step("R7 abort", 1, 0, 32'h4, 0, 1);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         int unsigned r = $urandom_range(99);
         bit w = r < 12;
         bit a = $urandom_range(1);
         logic [31:0] d = a ? ($urandom_range(3) == 0 ? 32'd0 : 32'($urandom_range(12)))
                            : 32'($urandom_range(7) & ($urandom_range(9) == 0 ? 7 : 3));
         step("R9 random", w, a, d, $urandom_range(1), $urandom_range(2) == 0);
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule